// File: doc/BRIEF.md
# Write-Back Fully Associative Cache

This block sits between a processor load/store port and a word-wide backing memory. It holds a small number of lines, each two words wide. Any memory block may occupy any line. Stores are kept in the cache and only marked as modified. Memory is updated when a modified line is pushed out to make room, or when a flush is requested. On a miss, whether from a load or a store, the whole block is fetched and the line is allocated. The victim line is an empty line if one exists, and otherwise the least recently used line.

Misses are handled by a sequencer. It first drains a modified victim as two consecutive word writes, then refills the line with two consecutive word reads. In its last step it installs the tag and merges any store data. The processor sees `cpu_ready` low until the sequencer is idle again. Each accepted access produces exactly one `resp_valid` pulse. The pulse carries the loaded word, or the stored word for a store. Two counters record how many accesses hit and how many missed.

A one-cycle `flush_req` pulse starts a scan of all lines in index order. Every modified line is written back and marked clean. Its valid state and contents are left in place, so later accesses to it still hit.

Top module: `wb_assoc_cache`

## Requirements
- R1: After reset every line is empty, both counters read 0, `cpu_ready` is 1, and `resp_valid`, `mem_rd` and `mem_we` are 0.
- R2: The address splits into tag = `cpu_addr[4:1]` and word offset = `cpu_addr[0]`, and any line may hold any tag. A load that hits returns the cached word with `resp_valid` one cycle after the request is accepted.
- R3: Every miss, load or store, reads the block in two consecutive `mem_rd` cycles. Address `{tag,0}` is read first and then `{tag,1}`. The response follows one cycle after the last read.
- R4: A load miss allocates the line valid and clean and returns the freshly fetched word.
- R5: A store hit writes only the cache and marks the line modified. It causes no memory write, and the response returns the stored word.
- R6: A store miss fetches the block, merges the store word and marks the line modified. The other word of the line keeps the value fetched from memory.
- R7: The victim is the lowest-index empty line if any line is empty. Otherwise it is the least recently used line, where loads and stores both count as uses.
- R8: Replacing an unmodified line performs no memory write.
- R9: Replacing a modified line first writes both of its words, in two consecutive `mem_we` cycles at `{old_tag,0}` then `{old_tag,1}`. These writes complete before the first refill read.
- R10: `hit_count` rises by one for each accepted access that hits, and `miss_count` rises by one for each accepted access that misses.
- R11: A flush writes back every modified line, two words each, and leaves the line valid but clean. Later hits on that line and its later eviction cause no memory write. `cpu_ready` is 0 while the flush runs.
- R12: `cpu_ready` is 0 from the cycle after a miss is accepted until the sequencer returns to idle. Each accepted access gives exactly one `resp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Store data |
| flush_req | input | 1 | Start a write-back of all modified lines |
| cpu_ready | output | 1 | Idle and able to take a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | DATA_W | Load result, or the stored word for a store |
| mem_rd | output | 1 | Memory word read this cycle; data returns on `mem_rdata` in the same cycle |
| mem_we | output | 1 | Memory word write this cycle |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| hit_count | output | CNT_W | Number of accesses that hit |
| miss_count | output | CNT_W | Number of accesses that missed |

## Verification
The bench follows an access trace that moves through every replacement case. It covers filling empty lines, evicting a clean victim, evicting a modified victim after both a load miss and a store miss, and hitting on lines that a flush has cleaned. After every access it compares the whole backing memory against an independent model. A design that wrote stores through, or that dropped the write-back of a modified victim, therefore shows wrong memory contents. A design that picked the wrong victim shows wrong hit and miss counts. A design that refilled before draining the victim is caught by an ordering check on the memory strobes. A flush that cleared valid instead of dirty turns later hits into misses. A flush that left lines dirty causes duplicate write-backs on the next eviction.

// File: rtl/wbc_pkg.sv
// Shared types for the write-back cache.
// Assumes nothing beyond IEEE 1800-2017 enums.
package wbc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request or flush
        ST_WBACK,  // draining a modified line to memory
        ST_FILL,   // fetching a block from memory
        ST_RESP,   // install tag, merge store, respond
        ST_FSCAN   // flush: walk the lines
    } seq_state_t;
endpackage

// File: rtl/wbc_line_store.sv
// Line storage: valid, dirty, tag and data words per line.
// One word write port, one tag write port and set/clear strobes for the
// status bits. Callers never set and clear the same bit in one cycle.
module wbc_line_store #(
    parameter int LINES  = 2,
    parameter int WORDS  = 2,
    parameter int DATA_W = 8,
    parameter int TAG_W  = 4,
    parameter int IDX_W  = 1,
    parameter int OFF_W  = 1
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     wr_en,
    input  logic [IDX_W-1:0]                         wr_line,
    input  logic [OFF_W-1:0]                         wr_off,
    input  logic [DATA_W-1:0]                        wr_data,
    input  logic                                     tag_we,
    input  logic [TAG_W-1:0]                         tag_in,
    input  logic [IDX_W-1:0]                         st_line,
    input  logic                                     v_set,
    input  logic                                     v_clr,
    input  logic                                     d_set,
    input  logic                                     d_clr,
    output logic [LINES-1:0]                         valid,
    output logic [LINES-1:0]                         dirty,
    output logic [LINES-1:0][TAG_W-1:0]              tags,
    output logic [LINES-1:0][WORDS-1:0][DATA_W-1:0]  words
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic sel_st;
        logic sel_wr;
        assign sel_st = (st_line == IDX_W'(i));
        assign sel_wr = (wr_line == IDX_W'(i));

        // Status bits of line i: set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[i] <= 1'b0;
                dirty[i] <= 1'b0;
            end else if (sel_st) begin
                if (v_set)      valid[i] <= 1'b1;
                else if (v_clr) valid[i] <= 1'b0;
                if (d_set)      dirty[i] <= 1'b1;
                else if (d_clr) dirty[i] <= 1'b0;
            end
        end

        // Tag and data of line i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tags[i]  <= '0;
                words[i] <= '0;
            end else begin
                if (tag_we && sel_st) tags[i] <= tag_in;
                if (wr_en && sel_wr)  words[i][wr_off] <= wr_data;
            end
        end

        AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            dirty[i] |-> valid[i]); // R5
    end
endmodule

// File: rtl/wbc_lru.sv
// Recency tracker: one age per line, 0 = most recent, LINES-1 = oldest.
// Assumes ages start as a permutation (reset gives line i age i).
module wbc_lru #(
    parameter int LINES = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_line,
    output logic [IDX_W-1:0] lru_line
);
    logic [LINES-1:0][IDX_W-1:0] age;
    logic [LINES-1:0]            is_old;
    logic [IDX_W-1:0]            touched_age;

    // Age of the line being used this cycle.
    always_comb begin
        touched_age = age[touch_line];
    end

    // Oldest-line decode.
    always_comb begin
        lru_line = '0;
        for (int i = 0; i < LINES; i++) begin
            is_old[i] = (age[i] == IDX_W'(LINES - 1));
            if (is_old[i]) lru_line = IDX_W'(i);
        end
    end

    // Age update: used line becomes youngest, younger ones move up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) age[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < LINES; i++) begin
                if (IDX_W'(i) == touch_line)  age[i] <= '0;
                else if (age[i] < touched_age) age[i] <= age[i] + 1'b1;
            end
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(is_old)); // R7
endmodule

// File: rtl/wbc_lookup.sv
// Tag compare and victim choice. Purely combinational apart from the
// assertion clock. Victim is the lowest empty line, else the LRU line.
module wbc_lookup #(
    parameter int LINES = 2,
    parameter int TAG_W = 4,
    parameter int IDX_W = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LINES-1:0]            valid,
    input  logic [LINES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            look_tag,
    input  logic [IDX_W-1:0]            lru_line,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_line,
    output logic [IDX_W-1:0]            victim_line
);
    logic [LINES-1:0] match;

    // Parallel compare against every line.
    always_comb begin
        hit_line    = '0;
        victim_line = lru_line;
        for (int i = LINES - 1; i >= 0; i--) begin
            match[i] = valid[i] && (tags[i] == look_tag);
            if (match[i])  hit_line    = IDX_W'(i);
            if (!valid[i]) victim_line = IDX_W'(i);
        end
        hit = |match;
    end

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R2
endmodule

// File: rtl/wb_assoc_cache.sv
// Fully associative write-back, write-allocate cache.
// Hits answer in one cycle. Misses run IDLE -> [WBACK] -> FILL -> RESP.
// A flush runs FSCAN/WBACK over all lines. Memory is word wide with a
// same-cycle read and a write taken at the clock edge.
// Assumes WORDS is a power of two, at least 2.
module wb_assoc_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int LINES  = 2,
    parameter int WORDS  = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              flush_req,
    output logic              cpu_ready,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1;
    localparam int FIDX_W = $clog2(LINES + 1);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

    seq_state_t state;

    logic [LINES-1:0]                        valid, dirty;
    logic [LINES-1:0][TAG_W-1:0]             tags;
    logic [LINES-1:0][WORDS-1:0][DATA_W-1:0] words;

    logic              look_hit;
    logic [IDX_W-1:0]  hit_line, victim_line, lru_line;
    logic [TAG_W-1:0]  cpu_tag;
    logic [OFF_W-1:0]  cpu_off;
    logic              accept;

    logic              req_we;
    logic [TAG_W-1:0]  req_tag;
    logic [OFF_W-1:0]  req_off;
    logic [DATA_W-1:0] req_wdata;
    logic [IDX_W-1:0]  tgt;
    logic [OFF_W-1:0]  wcnt;
    logic [FIDX_W-1:0] fidx;
    logic              flush_mode;

    logic              wr_en, tag_we, v_set, v_clr, d_set, d_clr, lru_touch;
    logic [IDX_W-1:0]  wr_line, st_line, lru_tline;
    logic [OFF_W-1:0]  wr_off;
    logic [DATA_W-1:0] wr_data;

    assign cpu_tag   = cpu_addr[ADDR_W-1:OFF_W];
    assign cpu_off   = cpu_addr[OFF_W-1:0];
    assign cpu_ready = (state == ST_IDLE) && !flush_req;
    assign accept    = cpu_ready && cpu_req;

    wbc_line_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W),
                     .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_line(wr_line), .wr_off(wr_off), .wr_data(wr_data),
        .tag_we(tag_we), .tag_in(req_tag), .st_line(st_line),
        .v_set(v_set), .v_clr(v_clr), .d_set(d_set), .d_clr(d_clr),
        .valid(valid), .dirty(dirty), .tags(tags), .words(words)
    );

    wbc_lookup #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lookup (
        .clk(clk), .rst_n(rst_n), .valid(valid), .tags(tags),
        .look_tag(cpu_tag), .lru_line(lru_line),
        .hit(look_hit), .hit_line(hit_line), .victim_line(victim_line)
    );

    wbc_lru #(.LINES(LINES), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch(lru_touch),
        .touch_line(lru_tline), .lru_line(lru_line)
    );

    // Per-state strobes to storage, recency tracker and memory.
    always_comb begin
        wr_en = 1'b0;  wr_line = '0;  wr_off = '0;  wr_data = '0;
        tag_we = 1'b0; st_line = '0;
        v_set = 1'b0;  v_clr = 1'b0;  d_set = 1'b0; d_clr = 1'b0;
        lru_touch = 1'b0; lru_tline = '0;
        mem_rd = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
        case (state)
            ST_IDLE: begin
                if (accept && look_hit) begin
                    lru_touch = 1'b1;
                    lru_tline = hit_line;
                    if (cpu_we) begin
                        wr_en   = 1'b1;
                        wr_line = hit_line;
                        wr_off  = cpu_off;
                        wr_data = cpu_wdata;
                        st_line = hit_line;
                        d_set   = 1'b1;
                    end
                end else if (accept && !(valid[victim_line] && dirty[victim_line])) begin
                    st_line = victim_line;
                    v_clr   = 1'b1;
                end
            end
            ST_WBACK: begin
                mem_we    = 1'b1;
                mem_addr  = {tags[tgt], wcnt};
                mem_wdata = words[tgt][wcnt];
                if (wcnt == LAST_OFF) begin
                    st_line = tgt;
                    d_clr   = 1'b1;
                    v_clr   = !flush_mode;
                end
            end
            ST_FILL: begin
                mem_rd   = 1'b1;
                mem_addr = {req_tag, wcnt};
                wr_en    = 1'b1;
                wr_line  = tgt;
                wr_off   = wcnt;
                wr_data  = mem_rdata;
            end
            ST_RESP: begin
                st_line   = tgt;
                v_set     = 1'b1;
                tag_we    = 1'b1;
                lru_touch = 1'b1;
                lru_tline = tgt;
                if (req_we) begin
                    wr_en   = 1'b1;
                    wr_line = tgt;
                    wr_off  = req_off;
                    wr_data = req_wdata;
                    d_set   = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Sequencer state, request capture, response and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            hit_count  <= '0;
            miss_count <= '0;
            req_we     <= 1'b0;
            req_tag    <= '0;
            req_off    <= '0;
            req_wdata  <= '0;
            tgt        <= '0;
            wcnt       <= '0;
            fidx       <= '0;
            flush_mode <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (flush_req) begin
                        flush_mode <= 1'b1;
                        fidx       <= '0;
                        state      <= ST_FSCAN;
                    end else if (cpu_req && look_hit) begin
                        hit_count  <= hit_count + 1'b1;
                        resp_valid <= 1'b1;
                        resp_rdata <= cpu_we ? cpu_wdata : words[hit_line][cpu_off];
                    end else if (cpu_req) begin
                        miss_count <= miss_count + 1'b1;
                        req_we     <= cpu_we;
                        req_tag    <= cpu_tag;
                        req_off    <= cpu_off;
                        req_wdata  <= cpu_wdata;
                        tgt        <= victim_line;
                        wcnt       <= '0;
                        state      <= (valid[victim_line] && dirty[victim_line])
                                      ? ST_WBACK : ST_FILL;
                    end
                end
                ST_WBACK: begin
                    wcnt <= wcnt + 1'b1;
                    if (wcnt == LAST_OFF) begin
                        wcnt <= '0;
                        if (flush_mode) begin
                            fidx  <= fidx + 1'b1;
                            state <= ST_FSCAN;
                        end else begin
                            state <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    wcnt <= wcnt + 1'b1;
                    if (wcnt == LAST_OFF) state <= ST_RESP;
                end
                ST_RESP: begin
                    resp_valid <= 1'b1;
                    resp_rdata <= req_we ? req_wdata : words[tgt][req_off];
                    state      <= ST_IDLE;
                end
                ST_FSCAN: begin
                    if (fidx == FIDX_W'(LINES)) begin
                        flush_mode <= 1'b0;
                        state      <= ST_IDLE;
                    end else if (valid[fidx[IDX_W-1:0]] && dirty[fidx[IDX_W-1:0]]) begin
                        tgt   <= fidx[IDX_W-1:0];
                        wcnt  <= '0;
                        state <= ST_WBACK;
                    end else begin
                        fidx <= fidx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_rd)); // R9
    AST_WB_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |=> mem_we); // R9
    AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we) && !flush_mode) |-> mem_rd); // R9
    AST_FILL_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |=> mem_rd); // R3
    AST_FILL_TO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |=> resp_valid); // R3
    AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        flush_mode |-> !cpu_ready); // R11
endmodule

// File: tb/sim_wb_assoc_cache.sv
// Scoreboard bench: the driver models each access from the requirements
// and queues the expected response; the monitor pops and compares.
module sim_wb_assoc_cache;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0, flush_req = 1'b0;
    logic [4:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_ready, resp_valid, mem_rd, mem_we;
    logic [7:0] resp_rdata, mem_wdata, mem_rdata;
    logic [4:0] mem_addr;
    logic [15:0] hit_count, miss_count;

    always #5 clk = ~clk;

    wb_assoc_cache u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .flush_req(flush_req),
        .cpu_ready(cpu_ready), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // Backing memory: same-cycle read, write at the edge.
    logic [7:0] bmem [32];
    assign mem_rdata = bmem[mem_addr];
    always @(posedge clk) if (mem_we) bmem[mem_addr] <= mem_wdata;

    int errors = 0, checks = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Independent model of the cache and memory.
    int exp_mem [32];
    bit mv [2];
    bit md [2];
    int mt [2];
    int mdat [2][2];
    int mru = 0, m_hits = 0, m_miss = 0;

    typedef struct { int rdata; int hits; int misses; string tag; } exp_t;
    exp_t sb_q[$];

    // Memory activity observed during one operation.
    int wr_n, rd_n, wr_a0, rd_a0, rd_a1;
    bit order_bad;
    always @(negedge clk) begin
        if (mem_we) begin
            if (wr_n == 0) wr_a0 = int'(mem_addr);
            wr_n++;
            if (rd_n > 0) order_bad = 1'b1;
        end
        if (mem_rd) begin
            if (rd_n == 0) rd_a0 = int'(mem_addr);
            if (rd_n == 1) rd_a1 = int'(mem_addr);
            rd_n++;
        end
    end

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R12", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(int'(resp_rdata) == e.rdata, e.tag, "response data", int'(resp_rdata), e.rdata);
                chk(int'(hit_count) == e.hits, "R7", "hit_count", int'(hit_count), e.hits);
                chk(int'(miss_count) == e.misses, "R10", "miss_count", int'(miss_count), e.misses);
            end
        end
    end

    task automatic mem_compare(input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < 32; i++) if (int'(bmem[i]) != exp_mem[i]) bad = i;
        if (bad < 0) chk(1'b1, req, "memory image", 0, 0);
        else chk(1'b0, req, "memory word", int'(bmem[bad]), exp_mem[bad]);
    endtask

    task automatic access(input bit we, input int addr, input int wdata);
        int tag, off, ln, v, exp_wr, wr_base;
        bit hit, vdirty;
        exp_t e;
        tag = addr >> 1; off = addr & 1; ln = -1;
        for (int i = 0; i < 2; i++) if (mv[i] && mt[i] == tag) ln = i;
        hit = (ln >= 0); exp_wr = 0; wr_base = 0; vdirty = 1'b0;
        if (hit) begin
            m_hits++;
            if (we) begin mdat[ln][off] = wdata; md[ln] = 1'b1; end
        end else begin
            m_miss++;
            v = !mv[0] ? 0 : (!mv[1] ? 1 : 1 - mru);
            if (mv[v] && md[v]) begin
                vdirty = 1'b1; exp_wr = 2; wr_base = mt[v] * 2;
                exp_mem[wr_base] = mdat[v][0]; exp_mem[wr_base + 1] = mdat[v][1];
            end
            mdat[v][0] = exp_mem[tag * 2]; mdat[v][1] = exp_mem[tag * 2 + 1];
            mt[v] = tag; mv[v] = 1'b1; md[v] = we;
            if (we) mdat[v][off] = wdata;
            ln = v;
        end
        mru = ln;
        e.rdata = mdat[ln][off]; e.hits = m_hits; e.misses = m_miss;
        e.tag = hit ? (we ? "R5" : "R2") : (we ? "R6" : "R4");
        sb_q.push_back(e);

        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        wr_n = 0; rd_n = 0; order_bad = 1'b0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = 5'(addr); cpu_wdata = 8'(wdata);
        @(negedge clk);
        cpu_req = 1'b0;
        if (!hit) chk(!cpu_ready, "R12", "ready after miss", int'(cpu_ready), 0);
        while (sb_q.size() != 0) @(negedge clk);
        chk(wr_n == exp_wr, hit ? "R5" : (vdirty ? "R9" : "R8"), "memory writes", wr_n, exp_wr);
        if (vdirty) begin
            chk(wr_a0 == wr_base, "R9", "write-back address", wr_a0, wr_base);
            chk(!order_bad, "R9", "write-back before refill", int'(order_bad), 0);
        end
        chk(rd_n == (hit ? 0 : 2), "R3", "memory reads", rd_n, hit ? 0 : 2);
        if (!hit) begin
            chk(rd_a0 == tag * 2, "R3", "first fill address", rd_a0, tag * 2);
            chk(rd_a1 == tag * 2 + 1, "R3", "second fill address", rd_a1, tag * 2 + 1);
        end
        mem_compare(hit && we ? "R5" : "R9");
    endtask

    task automatic flush();
        int exp_wr;
        exp_wr = 0;
        for (int i = 0; i < 2; i++) if (mv[i] && md[i]) begin
            exp_mem[mt[i] * 2] = mdat[i][0]; exp_mem[mt[i] * 2 + 1] = mdat[i][1];
            md[i] = 1'b0; exp_wr += 2;
        end
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        wr_n = 0; rd_n = 0;
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        chk(!cpu_ready, "R11", "ready during flush", int'(cpu_ready), 0);
        while (!cpu_ready) @(negedge clk);
        chk(wr_n == exp_wr, "R11", "flush writes", wr_n, exp_wr);
        chk(rd_n == 0, "R11", "flush reads", rd_n, 0);
        mem_compare("R11");
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R12", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            bmem[i] = 8'((i * 29 + 7) & 255);
            exp_mem[i] = (i * 29 + 7) & 255;
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_ready, "R1", "ready after reset", int'(cpu_ready), 1);
        chk(hit_count == 0 && miss_count == 0, "R1", "counters after reset",
            int'(hit_count) + int'(miss_count), 0);
        chk(!resp_valid && !mem_rd && !mem_we, "R1", "strobes after reset",
            int'(resp_valid) + int'(mem_rd) + int'(mem_we), 0);

        // Fill both empty lines, hit, clean and dirty evictions.
        access(0, 1, 0);   access(0, 7, 0);   access(1, 0, 165);
        access(1, 5, 60);  access(0, 10, 0);  access(1, 5, 119);
        access(1, 10, 94); access(0, 5, 0);   access(0, 4, 0);
        // Flush, then hits on cleaned lines, then a clean eviction.
        flush();
        access(0, 11, 0);  access(0, 4, 0);   access(0, 20, 0);
        flush();
        // Store miss with a dirty victim.
        access(1, 3, 33);  access(1, 9, 44);  access(1, 17, 55);
        access(0, 16, 0);  access(1, 31, 77); access(0, 8, 0);
        // Sweep with mixed stores.
        for (int a = 0; a < 32; a++) begin
            if (a % 3 == 0) access(1, a, (a * 11 + 3) & 255);
            access(0, a, 0);
        end
        flush();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule